// File: doc/BRIEF.md
# Two-Level Blocked Tree Search Engine

The engine finds where a 32-bit query key falls inside a static, perfectly balanced binary search tree that sits in an external on-chip memory. The tree is stored in blocks. Each block holds a node key and the keys of its two children. One read therefore covers two tree levels. The query is compared against all three keys of a block at the same time. The three comparison results form a mask, and a small lookup turns that mask into a child index from 0 to 3. That index picks the block to read at the next level. When the tree depth is odd, a final stage reads a single key and resolves the last level with a one-bit decision.

Every block level has its own pipeline stage and its own memory read port. The engine can therefore accept one query per clock and returns the results in the order the queries arrived. The result is the leaf slot number. It is made by appending the child decision of every level, with the root level in the most significant bits. For a correctly sorted tree, the slot equals the number of stored keys that are strictly smaller than the query. The tree is padded with the all-ones key when fewer real keys are stored than tree positions exist.

Top module: `tsrch_engine`

## Requirements
- R1: While rst_ni is low, and on the first edges after it is released, res_valid_o, res_bad_o and every bit of rd_en_o are 0.
- R2: A comparison is true only when the query is strictly greater than the stored key. A query equal to a stored key goes to the left side of that key. A query of 0 always yields slot 0 with res_bad_o low.
- R3: The block mask is {q>right, q>node, q>left}. It maps 000, 001, 011 and 111 to child 0, 1, 2 and 3. Any other mask raises res_bad_o for that query and uses child 0. Example: node 41, left 23, right 61 and query 59 give child 2.
- R4: A block word packs node in bits [KEY_W-1:0], left in [2*KEY_W-1:KEY_W] and right in [3*KEY_W-1:2*KEY_W]. Pair stage s reads block address base(s) + prefix, where base(s) = (4^s-1)/3 and prefix is the 2s-bit path taken so far. The odd-depth stage reads at base(DEPTH/2) + prefix.
- R5: res_slot_o is the concatenation of the child decisions, with the root level first. For a sorted tree it equals the count of stored keys strictly below the query.
- R6: When DEPTH is odd, the last stage compares the query with the key in bits [KEY_W-1:0] of its read word and appends one bit (1 when the query is greater).
- R7: A query accepted on a clock edge gives its result 2*ceil(DEPTH/2) edges later. Queries may arrive on consecutive clocks, and their results keep the same order.
- R8: Positions padded with the all-ones key are never passed by a query. The all-ones query yields the count of real keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q_valid_i | input | 1 | Query present this cycle |
| q_key_i | input | KEY_W | Query key |
| rd_en_o | output | NSTG | Per-stage read enable |
| rd_addr_o | output | NSTG*ADDR_W | Per-stage block address, stage s at [s*ADDR_W +: ADDR_W] |
| rd_data_i | input | NPAIR*3*KEY_W + (DEPTH%2)*KEY_W | Read data, valid one cycle after rd_en_o; pair stage s at [s*3*KEY_W +: 3*KEY_W], odd stage above them |
| res_valid_o | output | 1 | Result present |
| res_slot_o | output | DEPTH | Leaf slot number |
| res_bad_o | output | 1 | An impossible mask was seen on the path |

## Verification
Once the pipeline fills, a new query enters stage 0 on the same clock that earlier queries are reading memory in later stages and an older result leaves the engine. The bench provokes this overlap by streaming its whole vector table on consecutive clocks with no gaps. It then checks every result in arrival order against the count of smaller keys. It also issues a lone query and checks the exact cycle in which each stage's address appears and the cycle in which the result comes out. A deliberately unsorted root block then shows that a bad mask flags only the queries that produce it.

// File: rtl/tsrch_pkg.sv
package tsrch_pkg;

  // first block address of pair level s: 1 + 4 + ... + 4^(s-1)
  function automatic int blk_base(input int s);
    int acc;
    int pw;
    acc = 0;
    pw  = 1;
    for (int i = 0; i < s; i++) begin
      acc += pw;
      pw  *= 4;
    end
    return acc;
  endfunction

  function automatic int blk_span(input int s);
    int pw;
    pw = 1;
    for (int i = 0; i < s; i++) pw *= 4;
    return pw;
  endfunction

  function automatic int blk_total(input int depth);
    return blk_base(depth / 2) + ((depth % 2 != 0) ? blk_span(depth / 2) : 0);
  endfunction

  function automatic int addr_bits(input int depth);
    int n;
    n = blk_total(depth);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tsrch_mask_lut.sv
module tsrch_mask_lut (
  input  logic [2:0] mask_i,
  output logic [1:0] child_o,
  output logic       bad_o
);
  always_comb begin
    bad_o   = 1'b0;
    child_o = 2'd0;
    unique case (mask_i)
      3'b000: child_o = 2'd0;
      3'b001: child_o = 2'd1;
      3'b011: child_o = 2'd2;
      3'b111: child_o = 2'd3;
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/tsrch_pair_stage.sv
module tsrch_pair_stage #(
  parameter int KEY_W  = 32,
  parameter int PATH_W = 4,
  parameter int ADDR_W = 4,
  parameter int BASE   = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_v_i,
  input  logic [PATH_W-1:0]   in_p_i,
  input  logic                in_bad_i,
  input  logic [KEY_W-1:0]    key_i,
  output logic                rd_en_o,
  output logic [ADDR_W-1:0]   rd_addr_o,
  input  logic [3*KEY_W-1:0]  rd_data_i,
  output logic                out_v_o,
  output logic [PATH_W-1:0]   out_p_o,
  output logic                out_bad_o
);
  logic              v_a, v_b, bad_a, bad_b;
  logic [PATH_W-1:0] p_a, p_b;
  logic [KEY_W-1:0]  k_node, k_left, k_right;
  logic [2:0]        mask;
  logic [1:0]        child;
  logic              lut_bad;

  // A: address issue, B: data return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_a   <= 1'b0;
      bad_a <= 1'b0;
      p_a   <= '0;
      v_b   <= 1'b0;
      bad_b <= 1'b0;
      p_b   <= '0;
    end else begin
      v_a   <= in_v_i;
      bad_a <= in_bad_i;
      p_a   <= in_p_i;
      v_b   <= v_a;
      bad_b <= bad_a;
      p_b   <= p_a;
    end
  end

  assign rd_en_o   = v_a;
  assign rd_addr_o = ADDR_W'(BASE) + ADDR_W'(p_a);

  assign k_node  = rd_data_i[KEY_W-1:0];
  assign k_left  = rd_data_i[2*KEY_W-1:KEY_W];
  assign k_right = rd_data_i[3*KEY_W-1:2*KEY_W];
  assign mask    = {key_i > k_right, key_i > k_node, key_i > k_left};

  tsrch_mask_lut u_lut (
    .mask_i  (mask),
    .child_o (child),
    .bad_o   (lut_bad)
  );

  assign out_v_o   = v_b;
  assign out_p_o   = (p_b << 2) | PATH_W'(child);
  assign out_bad_o = bad_b | (v_b & lut_bad);
endmodule

// File: rtl/tsrch_tail_stage.sv
module tsrch_tail_stage #(
  parameter int KEY_W  = 32,
  parameter int PATH_W = 5,
  parameter int ADDR_W = 5,
  parameter int BASE   = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_v_i,
  input  logic [PATH_W-1:0]   in_p_i,
  input  logic                in_bad_i,
  input  logic [KEY_W-1:0]    key_i,
  output logic                rd_en_o,
  output logic [ADDR_W-1:0]   rd_addr_o,
  input  logic [KEY_W-1:0]    rd_data_i,
  output logic                out_v_o,
  output logic [PATH_W-1:0]   out_p_o,
  output logic                out_bad_o
);
  logic              v_a, v_b, bad_a, bad_b;
  logic [PATH_W-1:0] p_a, p_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_a   <= 1'b0;
      bad_a <= 1'b0;
      p_a   <= '0;
      v_b   <= 1'b0;
      bad_b <= 1'b0;
      p_b   <= '0;
    end else begin
      v_a   <= in_v_i;
      bad_a <= in_bad_i;
      p_a   <= in_p_i;
      v_b   <= v_a;
      bad_b <= bad_a;
      p_b   <= p_a;
    end
  end

  assign rd_en_o   = v_a;
  assign rd_addr_o = ADDR_W'(BASE) + ADDR_W'(p_a);
  assign out_v_o   = v_b;
  assign out_p_o   = (p_b << 1) | PATH_W'(key_i > rd_data_i);
  assign out_bad_o = bad_b;
endmodule

// File: rtl/tsrch_engine.sv
module tsrch_engine #(
  parameter int KEY_W = 32,
  parameter int DEPTH = 5,
  localparam int NPAIR  = DEPTH / 2,
  localparam int HAS_TL = DEPTH % 2,
  localparam int NSTG   = NPAIR + HAS_TL,
  localparam int WORD_W = 3 * KEY_W,
  localparam int ADDR_W = tsrch_pkg::addr_bits(DEPTH),
  localparam int RD_W   = NPAIR * WORD_W + HAS_TL * KEY_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   q_valid_i,
  input  logic [KEY_W-1:0]       q_key_i,
  output logic [NSTG-1:0]        rd_en_o,
  output logic [NSTG*ADDR_W-1:0] rd_addr_o,
  input  logic [RD_W-1:0]        rd_data_i,
  output logic                   res_valid_o,
  output logic [DEPTH-1:0]       res_slot_o,
  output logic                   res_bad_o
);
  localparam int LAT = 2 * NSTG;

  logic [KEY_W-1:0] key_q [LAT];
  logic             v_s   [NSTG+1];
  logic [DEPTH-1:0] p_s   [NSTG+1];
  logic             bad_s [NSTG+1];

  // key rides alongside the stage registers; stage s compares with key_q[2s+1]
  always_ff @(posedge clk_i) begin
    key_q[0] <= q_key_i;
    for (int j = 1; j < LAT; j++) key_q[j] <= key_q[j-1];
  end

  assign v_s[0]   = q_valid_i;
  assign p_s[0]   = '0;
  assign bad_s[0] = 1'b0;

  for (genvar s = 0; s < NPAIR; s++) begin : g_pair
    tsrch_pair_stage #(
      .KEY_W (KEY_W),
      .PATH_W(DEPTH),
      .ADDR_W(ADDR_W),
      .BASE  (tsrch_pkg::blk_base(s))
    ) u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .in_v_i    (v_s[s]),
      .in_p_i    (p_s[s]),
      .in_bad_i  (bad_s[s]),
      .key_i     (key_q[2*s+1]),
      .rd_en_o   (rd_en_o[s]),
      .rd_addr_o (rd_addr_o[s*ADDR_W +: ADDR_W]),
      .rd_data_i (rd_data_i[s*WORD_W +: WORD_W]),
      .out_v_o   (v_s[s+1]),
      .out_p_o   (p_s[s+1]),
      .out_bad_o (bad_s[s+1])
    );
  end

  if (HAS_TL != 0) begin : g_tail
    tsrch_tail_stage #(
      .KEY_W (KEY_W),
      .PATH_W(DEPTH),
      .ADDR_W(ADDR_W),
      .BASE  (tsrch_pkg::blk_base(NPAIR))
    ) u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .in_v_i    (v_s[NPAIR]),
      .in_p_i    (p_s[NPAIR]),
      .in_bad_i  (bad_s[NPAIR]),
      .key_i     (key_q[LAT-1]),
      .rd_en_o   (rd_en_o[NPAIR]),
      .rd_addr_o (rd_addr_o[NPAIR*ADDR_W +: ADDR_W]),
      .rd_data_i (rd_data_i[NPAIR*WORD_W +: KEY_W]),
      .out_v_o   (v_s[NSTG]),
      .out_p_o   (p_s[NSTG]),
      .out_bad_o (bad_s[NSTG])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_slot_o  <= '0;
      res_bad_o   <= 1'b0;
    end else begin
      res_valid_o <= v_s[NSTG];
      res_slot_o  <= p_s[NSTG];
      res_bad_o   <= v_s[NSTG] & bad_s[NSTG];
    end
  end
endmodule

// File: rtl/tsrch_engine_chk.sv
module tsrch_engine_chk #(
  parameter int KEY_W = 32,
  parameter int DEPTH = 5,
  localparam int NPAIR  = DEPTH / 2,
  localparam int NSTG   = NPAIR + DEPTH % 2,
  localparam int ADDR_W = tsrch_pkg::addr_bits(DEPTH),
  localparam int LAT    = 2 * NSTG
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   q_valid_i,
  input logic [KEY_W-1:0]       q_key_i,
  input logic [NSTG-1:0]        rd_en_o,
  input logic [NSTG*ADDR_W-1:0] rd_addr_o,
  input logic                   res_valid_o,
  input logic [DEPTH-1:0]       res_slot_o,
  input logic                   res_bad_o
);
  logic [LAT:0]      vsr, zsr;
  logic [ADDR_W-1:0] off [NSTG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsr <= '0;
      zsr <= '0;
    end else begin
      vsr <= {vsr[LAT-1:0], q_valid_i};
      zsr <= {zsr[LAT-1:0], q_valid_i && (q_key_i == '0)};
    end
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    localparam int BASE = tsrch_pkg::blk_base(s);
    localparam int SPAN = tsrch_pkg::blk_span(s);

    assign off[s] = rd_addr_o[s*ADDR_W +: ADDR_W] - ADDR_W'(BASE);

    a_r4_rd_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_o[s] == vsr[2*s]);

    a_r4_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_o[s] |-> (32'(off[s]) < SPAN));

    if (s > 0) begin : g_chain
      a_r5_prefix_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_o[s] |-> ((off[s] >> 2) == $past(off[s-1], 2)));
    end
  end

  a_r7_out_tracks_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == vsr[LAT]);

  a_r2_zero_key_slot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zsr[LAT] |-> (res_valid_o && res_slot_o == '0 && !res_bad_o));

  a_r1_bad_only_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_bad_o |-> res_valid_o);
endmodule

bind tsrch_engine tsrch_engine_chk #(
  .KEY_W(KEY_W),
  .DEPTH(DEPTH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .q_valid_i  (q_valid_i),
  .q_key_i    (q_key_i),
  .rd_en_o    (rd_en_o),
  .rd_addr_o  (rd_addr_o),
  .res_valid_o(res_valid_o),
  .res_slot_o (res_slot_o),
  .res_bad_o  (res_bad_o)
);

// File: tb/tsrch_engine_test.sv
module tsrch_engine_test;
  localparam int KEY_W  = 32;
  localparam int DEPTH  = 5;
  localparam int NPAIR  = DEPTH / 2;
  localparam int HAS_TL = DEPTH % 2;
  localparam int NSTG   = NPAIR + HAS_TL;
  localparam int WORD_W = 3 * KEY_W;
  localparam int ADDR_W = tsrch_pkg::addr_bits(DEPTH);
  localparam int NBLK   = tsrch_pkg::blk_total(DEPTH);
  localparam int RD_W   = NPAIR * WORD_W + HAS_TL * KEY_W;
  localparam int NKEY   = (1 << DEPTH) - 1;
  localparam int NREAL  = 25;
  localparam int NVEC   = 16;

  // {query, expected slot}; keys are 5,15,...,245 then all-ones padding
  localparam logic [KEY_W+DEPTH-1:0] VEC [NVEC] = '{
    {32'd0,          5'd0},   // R2 zero
    {32'd5,          5'd0},   // R2 equal goes left
    {32'd6,          5'd1},
    {32'd15,         5'd1},   // R2
    {32'd16,         5'd2},
    {32'd25,         5'd2},   // R6 equal to leaf key
    {32'd26,         5'd3},   // R6 odd stage bit set
    {32'd100,        5'd10},
    {32'd105,        5'd10},
    {32'd106,        5'd11},
    {32'd123,        5'd12},
    {32'd200,        5'd20},
    {32'd245,        5'd24},
    {32'd246,        5'd25},  // R8
    {32'd1000,       5'd25},  // R8
    {32'hFFFF_FFFF,  5'd25}   // R8 max query
  };

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   q_valid_i = 1'b0;
  logic [KEY_W-1:0]       q_key_i = '0;
  logic [NSTG-1:0]        rd_en_o;
  logic [NSTG*ADDR_W-1:0] rd_addr_o;
  logic [RD_W-1:0]        rd_data_i;
  logic                   res_valid_o;
  logic [DEPTH-1:0]       res_slot_o;
  logic                   res_bad_o;

  always #10 clk_i = ~clk_i;

  tsrch_engine #(.KEY_W(KEY_W), .DEPTH(DEPTH)) uut (.*);

  // memory model: synchronous read, one cycle
  logic [WORD_W-1:0] mem [NBLK];
  logic [KEY_W-1:0]  skey [NKEY];
  logic [WORD_W-1:0] rq [NSTG];

  for (genvar s = 0; s < NSTG; s++) begin : g_mem
    always_ff @(posedge clk_i)
      if (rd_en_o[s]) rq[s] <= mem[rd_addr_o[s*ADDR_W +: ADDR_W]];
    if (s < NPAIR) begin : g_p
      assign rd_data_i[s*WORD_W +: WORD_W] = rq[s];
    end else begin : g_t
      assign rd_data_i[NPAIR*WORD_W +: KEY_W] = rq[s][KEY_W-1:0];
    end
  end

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  logic [DEPTH-1:0] e_slot [64];
  logic [DEPTH-1:0] e_mask [64];
  logic             e_bad  [64];
  string            e_tag  [64];
  int wr = 0;
  int rd = 0;

  function automatic int io_idx(input int d, input int p);
    return (2 * p + 1) * (1 << (DEPTH - 1 - d)) - 1;
  endfunction

  task automatic build_tree();
    for (int i = 0; i < NKEY; i++)
      skey[i] = (i < NREAL) ? KEY_W'(10 * i + 5) : '1;
    for (int s = 0; s < NPAIR; s++)
      for (int p = 0; p < tsrch_pkg::blk_span(s); p++)
        mem[tsrch_pkg::blk_base(s) + p] =
          {skey[io_idx(2*s+1, 2*p+1)], skey[io_idx(2*s+1, 2*p)], skey[io_idx(2*s, p)]};
    if (HAS_TL != 0)
      for (int p = 0; p < tsrch_pkg::blk_span(NPAIR); p++)
        mem[tsrch_pkg::blk_base(NPAIR) + p] = {{(2*KEY_W){1'b0}}, skey[io_idx(DEPTH-1, p)]};
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [KEY_W-1:0] q, input logic [DEPTH-1:0] slot,
                      input logic [DEPTH-1:0] mask, input logic bad, input string tag);
    q_valid_i = 1'b1;
    q_key_i   = q;
    e_slot[wr % 64] = slot;
    e_mask[wr % 64] = mask;
    e_bad[wr % 64]  = bad;
    e_tag[wr % 64]  = tag;
    wr++;
  endtask

  task automatic drain();
    for (int i = 0; i < 2 * NSTG + 4 && rd != wr; i++) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    check(rd == wr, "R7", "results received", rd, wr);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  // in-order result monitor
  always @(negedge clk_i) begin
    if (rst_ni && res_valid_o) begin
      if (rd == wr) begin
        check(1'b0, "R7", "unexpected result", int'(res_slot_o), -1);
      end else begin
        check(((res_slot_o ^ e_slot[rd % 64]) & e_mask[rd % 64]) == '0, e_tag[rd % 64],
              "slot", int'(res_slot_o), int'(e_slot[rd % 64]));
        check(res_bad_o == e_bad[rd % 64], e_tag[rd % 64], "bad flag",
              int'(res_bad_o), int'(e_bad[rd % 64]));
        rd++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    check(1'b0, "watchdog", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    logic [WORD_W-1:0] saved;
    logic [DEPTH-1:0]  top2;
    build_tree();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(res_valid_o == 1'b0 && rd_en_o == '0 && res_bad_o == 1'b0, "R1",
          "outputs in reset", int'({res_valid_o, rd_en_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(res_valid_o == 1'b0 && rd_en_o == '0, "R1", "idle after reset",
          int'({res_valid_o, rd_en_o}), 0);

    // back-to-back stream, R5 R2 R6 R8 R7
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][KEY_W+DEPTH-1:DEPTH], VEC[i][DEPTH-1:0], '1, 1'b0, "R5");
      @(negedge clk_i);
    end
    q_valid_i = 1'b0;
    drain();

    // single query: per-stage address timing R4, latency R7 (slot 11)
    send(32'd106, 5'd11, '1, 1'b0, "R7");
    for (int k = 1; k <= 2 * NSTG + 1; k++) begin
      @(negedge clk_i);
      if (k == 1) q_valid_i = 1'b0;
      for (int s = 0; s < NSTG; s++) begin
        if (k == 2 * s + 1) begin
          int exp_a;
          exp_a = tsrch_pkg::blk_base(s) + (11 >> (DEPTH - 2 * s));
          check(rd_en_o[s] == 1'b1 &&
                int'(rd_addr_o[s*ADDR_W +: ADDR_W]) == exp_a, "R4",
                "stage address", int'(rd_addr_o[s*ADDR_W +: ADDR_W]), exp_a);
        end
      end
      if (k == 2 * NSTG) check(res_valid_o == 1'b0, "R7", "early result", int'(res_valid_o), 0);
      if (k == 2 * NSTG + 1) check(res_valid_o == 1'b1, "R7", "result on time", int'(res_valid_o), 1);
    end
    drain();

    // R3 mask lookup with a rewritten root block
    saved = mem[0];
    top2  = DEPTH'(3) << (DEPTH - 2);
    mem[0] = {32'd61, 32'd23, 32'd41};
    send(32'd59, DEPTH'(2) << (DEPTH - 2), top2, 1'b0, "R3");
    @(negedge clk_i);
    q_valid_i = 1'b0;
    drain();
    mem[0] = {32'd300, 32'd200, 32'd100};  // left above node: unsorted
    send(32'd150, '0, '0, 1'b1, "R3");
    @(negedge clk_i);
    send(32'd350, DEPTH'(3) << (DEPTH - 2), top2, 1'b0, "R3");
    @(negedge clk_i);
    send(32'd50, '0, top2, 1'b0, "R3");
    @(negedge clk_i);
    q_valid_i = 1'b0;
    drain();
    mem[0] = saved;

    finish_run();
  end
endmodule